// File: doc/BRIEF.md
# Configurable Boot Mode Selector

This block decides, once per reset, which boot mode a device should enter. It reads two configuration sources: a debug-side word pair that applies when an emulator is attached, and a one-time-programmable (OTP) word pair that applies otherwise. Each source has a 32-bit selector word and a 64-bit table of eight definition bytes. The selector word carries a key byte and three pin-selector bytes. A selector byte names a boot pin, and the level of that pin supplies one bit of a table index. A selector byte of 0xFF switches that bit off, so zero to three pins can choose among one, two, four or eight table entries.

The key byte controls the path. If it is not valid, the block uses a fixed result. With an emulator attached and an unknown debug key, the result is the wait mode. Without an emulator, an unknown OTP key falls back to two fixed strap pins. The chosen byte is split into a mode code and an option field. Both are latched on the first clock edge after reset is released, and a valid flag rises one cycle later. The result then holds until the next reset, so the boot firmware can read stable values.

Top module: `boot_mode_select`

## Requirements
- R1: While reset is asserted, boot_mode, boot_opt and boot_valid are all 0.
- R2: The result is captured on the first rising clock edge after reset is released. boot_valid is 0 after that edge and becomes 1 on the second edge.
- R3: Once captured, boot_mode and boot_opt ignore all input changes until the next reset.
- R4: With emu_present=1 and debug key (dbg_cfg[31:24]) equal to 0x5A, the index is formed from dbg_cfg and the entry is taken from dbg_def.
- R5: With emu_present=1 and debug key 0xA5, the result is the one the no-emulator flow (R7, R8) gives from the OTP inputs.
- R6: With emu_present=1 and any other debug key, boot_mode is 4 (wait) and boot_opt is 0.
- R7: With the no-emulator flow and OTP key (otp_cfg[31:24]) equal to 0x5A, the index is formed from otp_cfg and the entry is taken from otp_def.
- R8: With the no-emulator flow and any other OTP key, the index is {pin 24 level, pin 32 level} (pin 24 is the MSB). boot_mode equals that index (0 parallel, 1 SCI/wait, 2 CAN, 3 flash) and boot_opt is 0.
- R9: In a selector word, bits 23:16, 15:8 and 7:0 hold pin numbers for index bits 2, 1 and 0. Each index bit is the level of the named pin in pin_levels.
- R10: A selector byte of 0xFF makes its index bit 0. When all three selector bytes are 0xFF, entry 0 is used.
- R11: Entry k sits in bits 8k+7:8k of the definition table. boot_mode is the byte's bits 4:0 and boot_opt is its bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_present | input | 1 | Emulator attached |
| dbg_cfg | input | 32 | Debug-side key and selector word |
| dbg_def | input | 64 | Debug-side definition table |
| otp_cfg | input | 32 | OTP key and selector word |
| otp_def | input | 64 | OTP definition table |
| pin_levels | input | NUM_PINS | Boot pin levels, indexed by pin number |
| boot_mode | output | 5 | Selected mode code |
| boot_opt | output | 3 | Selected option field |
| boot_valid | output | 1 | Result captured and stable |

## Verification
The bench covers every combination of emulator presence, four debug keys (0x5A, 0xA5 and two invalid values) and two OTP keys. It crosses these with four selector layouts (all three pins, none, only the middle field, and the strap pins named explicitly) and sixteen pin-level patterns. These patterns separate the selector paths from the strap fallback, check that each field lands on the correct index bit, and check that unused fields read as 0. The two definition tables hold a distinct byte in every entry, so a wrong source, a wrong byte lane, or a mode/option split at the wrong bit shows up as a mismatch. Separate runs check the capture timing and confirm that inputs changed after capture have no effect.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int KEY_W   = 8;
    localparam int FIELD_W = 8;
    localparam int NUM_SEL = 3;
    localparam int ENTRY_W = 8;
    localparam int MODE_W  = 5;
    localparam int OPT_W   = ENTRY_W - MODE_W;
    localparam int ENTRIES = 1 << NUM_SEL;
    localparam int CFG_W   = KEY_W + NUM_SEL * FIELD_W;
    localparam int DEF_W   = ENTRIES * ENTRY_W;

    localparam logic [KEY_W-1:0]   KEY_DIRECT   = 8'h5A;
    localparam logic [KEY_W-1:0]   KEY_REDIRECT = 8'hA5;
    localparam logic [FIELD_W-1:0] FIELD_OFF    = 8'hFF;
    localparam logic [MODE_W-1:0]  MODE_WAIT    = 5'd4;

    typedef enum logic [1:0] {
        SRC_WAIT  = 2'd0,
        SRC_DEBUG = 2'd1,
        SRC_OTP   = 2'd2,
        SRC_STRAP = 2'd3
    } src_e;

    typedef struct packed {
        logic              cap;
        logic              valid;
        logic [MODE_W-1:0] mode;
        logic [OPT_W-1:0]  opt;
    } sel_state_t;
endpackage

// File: rtl/bsel_source.sv
module bsel_source
    import bsel_pkg::*;
(
    input  logic             emu_present,
    input  logic [KEY_W-1:0] dbg_key,
    input  logic [KEY_W-1:0] otp_key,
    output src_e             src
);
    logic standalone_flow;
    logic otp_key_ok;

    always_comb begin
        otp_key_ok      = (otp_key == KEY_DIRECT);
        standalone_flow = !emu_present || (dbg_key == KEY_REDIRECT);
        if (standalone_flow) begin
            src = otp_key_ok ? SRC_OTP : SRC_STRAP;
        end else if (dbg_key == KEY_DIRECT) begin
            src = SRC_DEBUG;
        end else begin
            src = SRC_WAIT;
        end
    end
endmodule

// File: rtl/bsel_index.sv
module bsel_index
    import bsel_pkg::*;
#(
    parameter int NUM_PINS = 255
) (
    input  logic [NUM_SEL*FIELD_W-1:0] sel_word,
    input  logic [NUM_PINS-1:0]        pin_levels,
    output logic [NUM_SEL-1:0]         idx
);
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_field
        logic [FIELD_W-1:0] field_d;
        logic               in_use;
        always_comb begin
            field_d = sel_word[k*FIELD_W +: FIELD_W];
            in_use  = (field_d != FIELD_OFF) && (int'(field_d) < NUM_PINS);
            idx[k]  = in_use ? pin_levels[field_d] : 1'b0;
        end
    end
endmodule

// File: rtl/bsel_entry.sv
module bsel_entry
    import bsel_pkg::*;
(
    input  logic [DEF_W-1:0]   defs,
    input  logic [NUM_SEL-1:0] idx,
    output logic [MODE_W-1:0]  mode,
    output logic [OPT_W-1:0]   opt
);
    logic [ENTRY_W-1:0] entry_d;

    always_comb begin
        entry_d = defs[idx*ENTRY_W +: ENTRY_W];
        mode    = entry_d[MODE_W-1:0];
        opt     = entry_d[ENTRY_W-1:MODE_W];
    end
endmodule

// File: rtl/boot_mode_select.sv
module boot_mode_select
    import bsel_pkg::*;
#(
    parameter int NUM_PINS    = 255,
    parameter int STRAP_HI    = 24,
    parameter int STRAP_LO    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emu_present,
    input  logic [31:0]         dbg_cfg,
    input  logic [63:0]         dbg_def,
    input  logic [31:0]         otp_cfg,
    input  logic [63:0]         otp_def,
    input  logic [NUM_PINS-1:0] pin_levels,
    output logic [4:0]          boot_mode,
    output logic [2:0]          boot_opt,
    output logic                boot_valid
);
    localparam int SEL_W = NUM_SEL * FIELD_W;

    src_e               src;
    logic [CFG_W-1:0]   cfg_mux;
    logic [DEF_W-1:0]   def_mux;
    logic [NUM_SEL-1:0] idx;
    logic [MODE_W-1:0]  tbl_mode;
    logic [OPT_W-1:0]   tbl_opt;
    logic [1:0]         strap_idx;
    sel_state_t         st_d, st_q;

    bsel_source i_source (
        .emu_present (emu_present),
        .dbg_key     (dbg_cfg[CFG_W-1 -: KEY_W]),
        .otp_key     (otp_cfg[CFG_W-1 -: KEY_W]),
        .src         (src)
    );

    always_comb begin
        cfg_mux   = (src == SRC_DEBUG) ? dbg_cfg : otp_cfg;
        def_mux   = (src == SRC_DEBUG) ? dbg_def : otp_def;
        strap_idx = {pin_levels[STRAP_HI], pin_levels[STRAP_LO]};
    end

    bsel_index #(.NUM_PINS(NUM_PINS)) i_index (
        .sel_word   (cfg_mux[SEL_W-1:0]),
        .pin_levels (pin_levels),
        .idx        (idx)
    );

    bsel_entry i_entry (
        .defs (def_mux),
        .idx  (idx),
        .mode (tbl_mode),
        .opt  (tbl_opt)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.cap) begin
            st_d.cap = 1'b1;
            unique case (src)
                SRC_WAIT: begin
                    st_d.mode = MODE_WAIT;
                    st_d.opt  = '0;
                end
                SRC_STRAP: begin
                    st_d.mode = {{(MODE_W-2){1'b0}}, strap_idx};
                    st_d.opt  = '0;
                end
                default: begin
                    st_d.mode = tbl_mode;
                    st_d.opt  = tbl_opt;
                end
            endcase
        end else begin
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boot_mode  = st_q.mode;
    assign boot_opt   = st_q.opt;
    assign boot_valid = st_q.valid;

    // R3
    hold_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cap |=> $stable({boot_mode, boot_opt}));

    // R2
    valid_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cap && !boot_valid) |=> boot_valid);

    // R2
    valid_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> st_q.cap);

    // R6
    wait_on_bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.cap) && $past(emu_present) &&
         $past(dbg_cfg[31:24]) != KEY_DIRECT && $past(dbg_cfg[31:24]) != KEY_REDIRECT)
        |-> (boot_mode == MODE_WAIT && boot_opt == 3'd0));

    // R8
    strap_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.cap) && !$past(emu_present) && $past(otp_cfg[31:24]) != KEY_DIRECT)
        |-> (boot_mode < 5'd4 && boot_opt == 3'd0));
endmodule

// File: tb/test_boot_mode_select.sv
module test_boot_mode_select;
    localparam int NP = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          emu_present = 1'b0;
    logic [31:0]   dbg_cfg = '0;
    logic [63:0]   dbg_def = '0;
    logic [31:0]   otp_cfg = '0;
    logic [63:0]   otp_def = '0;
    logic [NP-1:0] pin_levels = '0;
    logic [4:0]    boot_mode;
    logic [2:0]    boot_opt;
    logic          boot_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    boot_mode_select i_boot_mode_select (
        .clk(clk), .rst_n(rst_n), .emu_present(emu_present),
        .dbg_cfg(dbg_cfg), .dbg_def(dbg_def), .otp_cfg(otp_cfg), .otp_def(otp_def),
        .pin_levels(pin_levels), .boot_mode(boot_mode), .boot_opt(boot_opt),
        .boot_valid(boot_valid)
    );

    localparam logic [63:0] DBG_TBL = 64'hC8_24_05_E7_86_62_41_23;
    localparam logic [63:0] OTP_TBL = 64'h1B_A3_F0_66_47_81_3C_A2;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] make_idx(input logic [31:0] cfg, input logic [NP-1:0] p);
        logic [2:0] r;
        for (int k = 0; k < 3; k++) begin
            logic [7:0] f;
            f = cfg[8*k +: 8];
            r[k] = (f == 8'hFF) ? 1'b0 : p[f];
        end
        return r;
    endfunction

    // expected {mode, opt} plus the requirement tag that decides it
    task automatic expect_result(input logic emu, input logic [31:0] dc, input logic [63:0] dd,
                                 input logic [31:0] oc, input logic [63:0] od,
                                 input logic [NP-1:0] p,
                                 output logic [4:0] em, output logic [2:0] eo, output string tag);
        logic [7:0] b;
        logic [2:0] ix;
        if (emu && dc[31:24] == 8'h5A) begin
            ix = make_idx(dc, p);
            b = dd[8*ix +: 8];
            em = b[4:0]; eo = b[7:5]; tag = "R4/R9/R10/R11";
        end else if (emu && dc[31:24] != 8'hA5) begin
            em = 5'd4; eo = 3'd0; tag = "R6";
        end else if (oc[31:24] == 8'h5A) begin
            ix = make_idx(oc, p);
            b = od[8*ix +: 8];
            em = b[4:0]; eo = b[7:5]; tag = emu ? "R5/R7/R11" : "R7/R9/R10";
        end else begin
            em = {3'b000, p[24], p[32]}; eo = 3'd0; tag = emu ? "R5/R8" : "R8";
        end
    endtask

    task automatic boot(input logic emu, input logic [31:0] dc, input logic [63:0] dd,
                        input logic [31:0] oc, input logic [63:0] od, input logic [NP-1:0] p);
        @(negedge clk);
        rst_n = 1'b0;
        emu_present = emu; dbg_cfg = dc; dbg_def = dd;
        otp_cfg = oc; otp_def = od; pin_levels = p;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NP-1:0] pins_of(input int m);
        logic [NP-1:0] p;
        p = '0;
        p[3]   = m[0];
        p[7]   = m[1];
        p[100] = m[2];
        p[50]  = m[1] ^ m[3];
        p[24]  = m[3];
        p[32]  = m[0] ^ m[2];
        return p;
    endfunction

    initial begin
        logic [4:0] em;
        logic [2:0] eo;
        string tag;
        logic [23:0] layouts [4];
        logic [7:0]  dkeys [4];
        logic [7:0]  okeys [2];
        layouts[0] = {8'd100, 8'd7, 8'd3};
        layouts[1] = 24'hFFFFFF;
        layouts[2] = {8'hFF, 8'd50, 8'hFF};
        layouts[3] = {8'd24, 8'hFF, 8'd32};
        dkeys[0] = 8'h5A; dkeys[1] = 8'hA5; dkeys[2] = 8'h00; dkeys[3] = 8'h3C;
        okeys[0] = 8'h5A; okeys[1] = 8'h11;

        // R1: reset state
        rst_n = 1'b0;
        emu_present = 1'b1; dbg_cfg = {8'h5A, 24'hFFFFFF}; dbg_def = DBG_TBL;
        repeat (3) @(negedge clk);
        check("R1 mode in reset", 32'(boot_mode), 0);
        check("R1 opt in reset", 32'(boot_opt), 0);
        check("R1 valid in reset", 32'(boot_valid), 0);

        // R2: capture timing
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 valid after first edge", 32'(boot_valid), 0);
        check("R2 mode after first edge", 32'(boot_mode), 32'(5'(DBG_TBL[4:0])));
        @(posedge clk); @(negedge clk);
        check("R2 valid after second edge", 32'(boot_valid), 1);

        // main sweep
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 4; d++)
                for (int o = 0; o < 2; o++)
                    for (int l = 0; l < 4; l++)
                        for (int m = 0; m < 16; m++) begin
                            logic [31:0] dc, oc;
                            dc = {dkeys[d], layouts[l]};
                            oc = {okeys[o], layouts[(l + 1) % 4]};
                            boot(e[0], dc, DBG_TBL, oc, OTP_TBL, pins_of(m));
                            expect_result(e[0], dc, DBG_TBL, oc, OTP_TBL, pins_of(m), em, eo, tag);
                            check({tag, " mode"}, 32'(boot_mode), 32'(em));
                            check({tag, " opt"}, 32'(boot_opt), 32'(eo));
                            check("R2 valid", 32'(boot_valid), 1);
                        end

        // R3: inputs changed after capture have no effect
        boot(1'b1, {8'h5A, 8'd100, 8'd7, 8'd3}, DBG_TBL, 32'h0, OTP_TBL, pins_of(7));
        em = boot_mode; eo = boot_opt;
        emu_present = 1'b0; dbg_cfg = 32'h00FFFFFF; otp_cfg = {8'h11, 24'h0};
        dbg_def = ~DBG_TBL; pin_levels = ~pins_of(7);
        repeat (4) @(negedge clk);
        check("R3 mode held", 32'(boot_mode), 32'(em));
        check("R3 opt held", 32'(boot_opt), 32'(eo));
        check("R3 valid held", 32'(boot_valid), 1);
        check("R3 held value is entry 7", 32'({boot_opt, boot_mode}), 32'(DBG_TBL[63:56]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule